// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block forms the second source operand for a 32-bit data-processing ALU and the carry flag that a shifter would produce for it. The operand is built in one of three ways, chosen by a mode input. An 8-bit constant can be rotated right by an even amount. A register value can be shifted by a 5-bit amount taken from the instruction. A register value can also be shifted by the low byte of another register. Each of these ways gives the amounts zero and 32-or-more their own meaning, so the carry-out follows different rules in each. The shift kind is one of logical left, logical right, arithmetic right and rotate right.

The computation itself is combinational. It sits behind a single-entry output register with a valid/ready stream on each side. A request transfers on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or the consumer is taking its contents in the same cycle. This means back-pressure from `out_ready` reaches `in_ready` in the same cycle, without a register between them. While `out_valid` is high and `out_ready` is low, the output holds its word and carry unchanged, and no new request is taken. With `out_ready` held high, one request can be taken every cycle.

Top module: `shop_operand_unit`

## Requirements
- R1: Shift kind codes are 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. In both shift modes, a shift by an amount n with 0 < n < 32 gives the usual shifted or rotated word. Its carry-out is input bit n-1 for the three right-going kinds and input bit 32-n for a left shift.
- R2: Shift-by-immediate mode, logical left with amount 0: the word passes unchanged and the carry-out equals `in_carry`.
- R3: Shift-by-immediate mode, logical right with amount 0 acts as a shift by 32: the word is zero and the carry-out is input bit 31.
- R4: Shift-by-immediate mode, arithmetic right with amount 0 acts as a shift by 32: every bit is a copy of input bit 31, and so is the carry-out.
- R5: Shift-by-immediate mode, rotate right with amount 0 is a one-bit rotate through carry. The word moves right by one, `in_carry` enters bit 31, and the carry-out is input bit 0.
- R6: Shift-by-register mode with the full 8-bit amount equal to 0: the word passes unchanged and the carry-out equals `in_carry`, for every shift kind.
- R7: Shift-by-register mode, logical shifts by exactly 32 give a zero word. The carry-out is then input bit 0 for a left shift and input bit 31 for a right shift. Amounts from 33 to 255 give a zero word and a zero carry-out.
- R8: Shift-by-register mode, arithmetic right by 32 or more fills the word with input bit 31, and the carry-out is input bit 31.
- R9: Shift-by-register mode, rotate right uses only amount bits 4:0. A nonzero amount whose low five bits are zero leaves the word unchanged, and the carry-out is input bit 31.
- R10: Rotated-constant mode: the word is the zero-extended 8-bit constant rotated right by twice the 4-bit rotate field. The carry-out is `in_carry` when that field is 0 and bit 31 of the word otherwise.
- R11: Mode codes are 0 = rotated constant, 1 = shift by immediate, 2 and 3 = shift by register. Fields that the selected mode does not use have no effect on the result (the shift kind in mode 0, the constant and rotate field in modes 1 to 3, the other amount field).
- R12: A request transfers on a rising edge with `in_valid` and `in_ready` both high, and its result is on `out_operand`/`out_carry` with `out_valid` high from that edge on. `in_ready` equals (not `out_valid`) or `out_ready`. When `in_ready` is high and `in_valid` is low at an edge, `out_valid` is low after it.
- R13: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_operand` and `out_carry` keep their values, and a request offered meanwhile is taken only once `out_ready` rises.
- R14: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 2 | Operand mode (0 constant, 1 shift by immediate, 2/3 shift by register) |
| in_shift_type | input | 2 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| in_value | input | 32 | Register value to be shifted |
| in_imm_amt | input | 5 | Shift amount for shift-by-immediate mode |
| in_reg_amt | input | 8 | Shift amount for shift-by-register mode (low byte of the amount register) |
| in_imm | input | 8 | Constant for rotated-constant mode |
| in_rot | input | 4 | Rotate field; the constant rotates right by twice this value |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_operand | output | 32 | Shifted operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
Every result appears on `out_operand` and `out_carry` on the rising edge that accepts its request, so it is one clock after the inputs are presented. `in_ready` is combinational and is valid as soon as `out_ready` or `out_valid` changes. The bench changes inputs on falling edges and reads every output on the next falling edge, half a period after the accepting edge. It reads `in_ready` a moment after changing `out_ready`. During a stall it samples on each falling edge to confirm that the held word does not move, and that the waiting request comes out exactly one edge after `out_ready` rises.

// File: rtl/shop_pkg.sv
package shop_pkg;

  // Shift kind as carried on in_shift_type.
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  // Operand mode as carried on in_mode; bit 1 alone selects register amount.
  typedef enum logic [1:0] {
    OM_ROT_CONST = 2'd0,
    OM_SH_IMM    = 2'd1,
    OM_SH_REG    = 2'd2,
    OM_SH_REG_B  = 2'd3
  } opnd_mode_e;

  // Amount class after the special encodings have been resolved.
  typedef enum logic [1:0] {
    NC_SHIFT = 2'd0,  // ordinary shift by count 0..DATA_W
    NC_PASS  = 2'd1,  // word and carry pass through
    NC_RRX   = 2'd2,  // one-bit rotate through carry
    NC_CLEAR = 2'd3   // zero word, zero carry
  } norm_class_e;

endpackage

// File: rtl/shop_rotr.sv
module shop_rotr #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] dout
);

  // Logarithmic rotate-right: one 2:1 mux stage per amount bit.
  logic [DATA_W-1:0] stg [SH_W+1];

  assign stg[0] = din;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][STEP-1:0], stg[s][DATA_W-1:STEP]}
                             : stg[s];
  end

  assign dout = stg[SH_W];

endmodule

// File: rtl/shop_amt_imm.sv
module shop_amt_imm
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  shift_kind_e   kind,
  input  logic [SH_W-1:0] amt,
  output norm_class_e   cls,
  output logic [SH_W:0] cnt
);

  localparam logic [SH_W:0] FULL_CNT = (SH_W+1)'(DATA_W);

  // A zero immediate amount is an escape code whose meaning depends on kind.
  always_comb begin
    cls = NC_SHIFT;
    cnt = {1'b0, amt};
    if (amt == '0) begin
      unique case (kind)
        SK_LSL:         cls = NC_PASS;
        SK_LSR, SK_ASR: cnt = FULL_CNT;
        SK_ROR:         cls = NC_RRX;
        default:        cls = NC_PASS;
      endcase
    end
  end

endmodule

// File: rtl/shop_amt_reg.sv
module shop_amt_reg
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  shift_kind_e      kind,
  input  logic [AMT_W-1:0] amt,
  output norm_class_e      cls,
  output logic [SH_W:0]    cnt
);

  localparam logic [SH_W:0]    FULL_CNT = (SH_W+1)'(DATA_W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic amt_zero, amt_full, amt_over;

  assign amt_zero = (amt == '0);
  assign amt_full = (amt == FULL_AMT);
  assign amt_over = (amt > FULL_AMT);

  // Register amounts saturate or wrap differently per kind.
  always_comb begin
    cls = NC_SHIFT;
    cnt = {1'b0, amt[SH_W-1:0]};
    if (amt_zero) begin
      cls = NC_PASS;
    end else begin
      unique case (kind)
        SK_LSL, SK_LSR: begin
          if (amt_over)      cls = NC_CLEAR;
          else if (amt_full) cnt = FULL_CNT;
        end
        SK_ASR: begin
          if (amt_over || amt_full) cnt = FULL_CNT;
        end
        SK_ROR:  cnt = {1'b0, amt[SH_W-1:0]};
        default: cls = NC_PASS;
      endcase
    end
  end

endmodule

// File: rtl/shop_shift_core.sv
module shop_shift_core
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value,
  input  shift_kind_e       kind,
  input  norm_class_e       cls,
  input  logic [SH_W:0]     cnt,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  localparam logic [DATA_W-1:0] ONES = '1;

  logic [SH_W-1:0]   rot_amt;
  logic [DATA_W-1:0] rot;
  logic [DATA_W-1:0] keep_hi;   // bits kept by a left shift
  logic [DATA_W-1:0] keep_lo;   // bits kept by a right shift
  logic [DATA_W-1:0] sign_fill;

  // Every kind is a right rotation; a left shift by n rotates by DATA_W-n.
  always_comb begin
    if (cls == NC_RRX)        rot_amt = SH_W'(1);
    else if (kind == SK_LSL)  rot_amt = '0 - cnt[SH_W-1:0];
    else                      rot_amt = cnt[SH_W-1:0];
  end

  shop_rotr #(.DATA_W(DATA_W)) u_rot (
    .din  (value),
    .amt  (rot_amt),
    .dout (rot)
  );

  assign keep_hi   = ONES << cnt;
  assign keep_lo   = ONES >> cnt;
  assign sign_fill = {DATA_W{value[DATA_W-1]}} & ~keep_lo;

  // The last bit shifted out lands at bit 0 (left) or bit DATA_W-1 (right).
  always_comb begin
    unique case (cls)
      NC_PASS: begin
        res  = value;
        cout = cin;
      end
      NC_CLEAR: begin
        res  = '0;
        cout = 1'b0;
      end
      NC_RRX: begin
        res  = {cin, rot[DATA_W-2:0]};
        cout = rot[DATA_W-1];
      end
      default: begin
        unique case (kind)
          SK_LSL: begin
            res  = rot & keep_hi;
            cout = rot[0];
          end
          SK_LSR: begin
            res  = rot & keep_lo;
            cout = rot[DATA_W-1];
          end
          SK_ASR: begin
            res  = (rot & keep_lo) | sign_fill;
            cout = rot[DATA_W-1];
          end
          default: begin
            res  = rot;
            cout = rot[DATA_W-1];
          end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/shop_rot_const.sv
module shop_rot_const #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROT_W-1:0]  rot,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  logic [SH_W-1:0] amt;

  // Rotate field counts pairs of bit positions.
  assign amt = SH_W'({rot, 1'b0});

  shop_rotr #(.DATA_W(DATA_W)) u_rot (
    .din  (DATA_W'(imm)),
    .amt  (amt),
    .dout (res)
  );

  assign cout = (rot == '0) ? cin : res[DATA_W-1];

endmodule

// File: rtl/shop_operand_unit.sv
module shop_operand_unit
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RAMT_W = 8,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [1:0]        in_shift_type,
  input  logic [DATA_W-1:0] in_value,
  input  logic [SH_W-1:0]   in_imm_amt,
  input  logic [RAMT_W-1:0] in_reg_amt,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [ROT_W-1:0]  in_rot,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_operand,
  output logic              out_carry
);

  localparam logic [RAMT_W-1:0] FULL_RAMT = RAMT_W'(DATA_W);

  opnd_mode_e  mode;
  shift_kind_e kind;
  logic        use_reg_amt;
  logic        use_const;

  assign mode        = opnd_mode_e'(in_mode);
  assign kind        = shift_kind_e'(in_shift_type);
  assign use_reg_amt = (mode == OM_SH_REG) || (mode == OM_SH_REG_B);
  assign use_const   = (mode == OM_ROT_CONST);

  // Amount normalisation for the two shift modes.
  norm_class_e   imm_cls, reg_cls, sel_cls;
  logic [SH_W:0] imm_cnt, reg_cnt, sel_cnt;

  shop_amt_imm #(.DATA_W(DATA_W)) u_amt_imm (
    .kind (kind),
    .amt  (in_imm_amt),
    .cls  (imm_cls),
    .cnt  (imm_cnt)
  );

  shop_amt_reg #(.DATA_W(DATA_W), .AMT_W(RAMT_W)) u_amt_reg (
    .kind (kind),
    .amt  (in_reg_amt),
    .cls  (reg_cls),
    .cnt  (reg_cnt)
  );

  assign sel_cls = use_reg_amt ? reg_cls : imm_cls;
  assign sel_cnt = use_reg_amt ? reg_cnt : imm_cnt;

  logic [DATA_W-1:0] sh_res, k_res, nxt_operand;
  logic              sh_cout, k_cout, nxt_carry;

  shop_shift_core #(.DATA_W(DATA_W)) u_core (
    .value (in_value),
    .kind  (kind),
    .cls   (sel_cls),
    .cnt   (sel_cnt),
    .cin   (in_carry),
    .res   (sh_res),
    .cout  (sh_cout)
  );

  shop_rot_const #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_const (
    .imm  (in_imm),
    .rot  (in_rot),
    .cin  (in_carry),
    .res  (k_res),
    .cout (k_cout)
  );

  assign nxt_operand = use_const ? k_res  : sh_res;
  assign nxt_carry   = use_const ? k_cout : sh_cout;

  // Single output register; ready passes straight through from the consumer.
  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_operand <= '0;
      out_carry   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_operand <= nxt_operand;
        out_carry   <= nxt_carry;
      end
    end
  end

  // Stream protocol checks.
  p_accept_shows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_idle_drains_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);

  p_stall_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_operand) && $stable(out_carry)));

  // Operand rule checks, relating accepted inputs to the registered result.
  p_const_norot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && use_const && in_rot == '0) |=>
      (out_operand == DATA_W'($past(in_imm)) && out_carry == $past(in_carry)));

  p_imm_lsl0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == OM_SH_IMM && kind == SK_LSL && in_imm_amt == '0) |=>
      (out_operand == $past(in_value) && out_carry == $past(in_carry)));

  p_imm_rrx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == OM_SH_IMM && kind == SK_ROR && in_imm_amt == '0) |=>
      (out_operand == {$past(in_carry), $past(in_value[DATA_W-1:1])} &&
       out_carry == $past(in_value[0])));

  p_reg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && use_reg_amt && in_reg_amt == '0) |=>
      (out_operand == $past(in_value) && out_carry == $past(in_carry)));

  p_reg_over_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && use_reg_amt && !in_shift_type[1] && in_reg_amt > FULL_RAMT) |=>
      (out_operand == '0 && !out_carry));

  p_reg_asr_big_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && use_reg_amt && kind == SK_ASR && in_reg_amt >= FULL_RAMT) |=>
      (out_operand == {DATA_W{$past(in_value[DATA_W-1])}} &&
       out_carry == $past(in_value[DATA_W-1])));

endmodule

// File: tb/shop_operand_unit_bench.sv
module shop_operand_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [1:0]  in_mode, in_shift_type;
  logic [31:0] in_value, out_operand;
  logic [4:0]  in_imm_amt;
  logic [7:0]  in_reg_amt, in_imm;
  logic [3:0]  in_rot;
  logic        in_carry, out_carry;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  shop_operand_unit u_shop_operand_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_mode       (in_mode),
    .in_shift_type (in_shift_type),
    .in_value      (in_value),
    .in_imm_amt    (in_imm_amt),
    .in_reg_amt    (in_reg_amt),
    .in_imm        (in_imm),
    .in_rot        (in_rot),
    .in_carry      (in_carry),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_operand   (out_operand),
    .out_carry     (out_carry)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  kind;
    logic [31:0] value;
    logic [4:0]  iamt;
    logic [7:0]  ramt;
    logic [7:0]  imm;
    logic [3:0]  rot;
    logic        cin;
    logic [31:0] eop;
    logic        ec;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VT [NV] = '{
    // R1 immediate amounts, one per kind
    '{2'd1, 2'd0, 32'hF0000001, 5'd4, 8'd0,   8'h00, 4'd0,  1'b0, 32'h00000010, 1'b1, 4'd1},
    '{2'd1, 2'd1, 32'h00000003, 5'd1, 8'd0,   8'h00, 4'd0,  1'b0, 32'h00000001, 1'b1, 4'd1},
    '{2'd1, 2'd2, 32'h80000080, 5'd8, 8'd0,   8'h00, 4'd0,  1'b0, 32'hFF800000, 1'b1, 4'd1},
    '{2'd1, 2'd3, 32'h12345678, 5'd4, 8'd0,   8'h00, 4'd0,  1'b0, 32'h81234567, 1'b1, 4'd1},
    // R2 left by zero passes carry
    '{2'd1, 2'd0, 32'hDEADBEEF, 5'd0, 8'd0,   8'h00, 4'd0,  1'b1, 32'hDEADBEEF, 1'b1, 4'd2},
    '{2'd1, 2'd0, 32'hDEADBEEF, 5'd0, 8'd0,   8'h00, 4'd0,  1'b0, 32'hDEADBEEF, 1'b0, 4'd2},
    // R3 logical right by zero means 32
    '{2'd1, 2'd1, 32'h80000000, 5'd0, 8'd0,   8'h00, 4'd0,  1'b0, 32'h00000000, 1'b1, 4'd3},
    '{2'd1, 2'd1, 32'h7FFFFFFF, 5'd0, 8'd0,   8'h00, 4'd0,  1'b1, 32'h00000000, 1'b0, 4'd3},
    // R4 arithmetic right by zero means 32
    '{2'd1, 2'd2, 32'h80000001, 5'd0, 8'd0,   8'h00, 4'd0,  1'b0, 32'hFFFFFFFF, 1'b1, 4'd4},
    '{2'd1, 2'd2, 32'h7FFFFFFF, 5'd0, 8'd0,   8'h00, 4'd0,  1'b1, 32'h00000000, 1'b0, 4'd4},
    // R5 rotate through carry
    '{2'd1, 2'd3, 32'h00000003, 5'd0, 8'd0,   8'h00, 4'd0,  1'b1, 32'h80000001, 1'b1, 4'd5},
    '{2'd1, 2'd3, 32'h80000002, 5'd0, 8'd0,   8'h00, 4'd0,  1'b0, 32'h40000001, 1'b0, 4'd5},
    // R6 register amount zero
    '{2'd2, 2'd0, 32'h12345678, 5'd0, 8'd0,   8'h00, 4'd0,  1'b1, 32'h12345678, 1'b1, 4'd6},
    '{2'd2, 2'd3, 32'h12345678, 5'd0, 8'd0,   8'h00, 4'd0,  1'b0, 32'h12345678, 1'b0, 4'd6},
    // R7 logical shifts at and beyond 32
    '{2'd2, 2'd0, 32'h00000001, 5'd0, 8'd32,  8'h00, 4'd0,  1'b0, 32'h00000000, 1'b1, 4'd7},
    '{2'd2, 2'd1, 32'h80000000, 5'd0, 8'd32,  8'h00, 4'd0,  1'b0, 32'h00000000, 1'b1, 4'd7},
    '{2'd2, 2'd0, 32'hFFFFFFFF, 5'd0, 8'd33,  8'h00, 4'd0,  1'b1, 32'h00000000, 1'b0, 4'd7},
    '{2'd2, 2'd1, 32'hFFFFFFFF, 5'd0, 8'd255, 8'h00, 4'd0,  1'b1, 32'h00000000, 1'b0, 4'd7},
    // R1 register left by 31
    '{2'd2, 2'd0, 32'h00000003, 5'd0, 8'd31,  8'h00, 4'd0,  1'b0, 32'h80000000, 1'b1, 4'd1},
    // R8 arithmetic at and beyond 32
    '{2'd2, 2'd2, 32'h80000000, 5'd0, 8'd32,  8'h00, 4'd0,  1'b0, 32'hFFFFFFFF, 1'b1, 4'd8},
    '{2'd2, 2'd2, 32'h70000000, 5'd0, 8'd200, 8'h00, 4'd0,  1'b1, 32'h00000000, 1'b0, 4'd8},
    // R1 register arithmetic right by 31
    '{2'd2, 2'd2, 32'h80000000, 5'd0, 8'd31,  8'h00, 4'd0,  1'b1, 32'hFFFFFFFF, 1'b0, 4'd1},
    // R9 rotate uses low five bits
    '{2'd2, 2'd3, 32'h87654321, 5'd0, 8'd32,  8'h00, 4'd0,  1'b0, 32'h87654321, 1'b1, 4'd9},
    '{2'd2, 2'd3, 32'h00000001, 5'd0, 8'd64,  8'h00, 4'd0,  1'b1, 32'h00000001, 1'b0, 4'd9},
    '{2'd2, 2'd3, 32'h12345678, 5'd0, 8'd36,  8'h00, 4'd0,  1'b0, 32'h81234567, 1'b1, 4'd9},
    // R1 register rotate by one
    '{2'd2, 2'd3, 32'h00000001, 5'd0, 8'd1,   8'h00, 4'd0,  1'b0, 32'h80000000, 1'b1, 4'd1},
    // R10 rotated constant
    '{2'd0, 2'd0, 32'h00000000, 5'd0, 8'd0,   8'hFF, 4'd0,  1'b1, 32'h000000FF, 1'b1, 4'd10},
    '{2'd0, 2'd0, 32'h00000000, 5'd0, 8'd0,   8'hFF, 4'd4,  1'b0, 32'hFF000000, 1'b1, 4'd10},
    '{2'd0, 2'd0, 32'h00000000, 5'd0, 8'd0,   8'h3F, 4'd1,  1'b0, 32'hC000000F, 1'b1, 4'd10},
    '{2'd0, 2'd0, 32'h00000000, 5'd0, 8'd0,   8'h01, 4'd15, 1'b1, 32'h00000004, 1'b0, 4'd10},
    '{2'd0, 2'd0, 32'h00000000, 5'd0, 8'd0,   8'h80, 4'd0,  1'b0, 32'h00000080, 1'b0, 4'd10},
    // R11 unused fields carry junk; mode 3 acts as register mode
    '{2'd0, 2'd3, 32'hDEADBEEF, 5'd5, 8'd9,   8'hFF, 4'd4,  1'b0, 32'hFF000000, 1'b1, 4'd11},
    '{2'd1, 2'd1, 32'h000000F0, 5'd4, 8'd255, 8'hAA, 4'd7,  1'b1, 32'h0000000F, 1'b0, 4'd11},
    '{2'd3, 2'd0, 32'h00000001, 5'd31, 8'd4,  8'h55, 4'd3,  1'b1, 32'h00000010, 1'b0, 4'd11}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report_and_end;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic drive(input vec_t v);
    in_valid      = 1'b1;
    in_mode       = v.mode;
    in_shift_type = v.kind;
    in_value      = v.value;
    in_imm_amt    = v.iamt;
    in_reg_amt    = v.ramt;
    in_imm        = v.imm;
    in_rot        = v.rot;
    in_carry      = v.cin;
  endtask

  // Watchdog: a hung run is a failed check and still reports.
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog expired: actual running expected done");
    report_and_end();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b1;
    in_mode = '0; in_shift_type = '0; in_value = '0; in_imm_amt = '0;
    in_reg_amt = '0; in_imm = '0; in_rot = '0; in_carry = 1'b0;

    repeat (3) @(negedge clk);
    chk("R14 out_valid during reset", 32'(out_valid), 32'd0);
    chk("R14 in_ready during reset",  32'(in_ready),  32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14 out_valid idle after reset", 32'(out_valid), 32'd0);

    // Streaming table: one request per cycle, result one edge later.
    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      @(negedge clk);
      chk($sformatf("R12 valid vector %0d", i), 32'(out_valid), 32'd1);
      chk($sformatf("R%0d operand vector %0d", VT[i].req, i), out_operand, VT[i].eop);
      chk($sformatf("R%0d carry vector %0d", VT[i].req, i), 32'(out_carry), 32'(VT[i].ec));
    end

    in_valid = 1'b0;
    @(negedge clk);
    chk("R12 valid drops when idle", 32'(out_valid), 32'd0);

    // R13 stall: first request held while a second waits.
    in_mode = 2'd1; in_shift_type = 2'd0; in_value = 32'h00000001;
    in_imm_amt = 5'd1; in_carry = 1'b1; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk("R13 first operand", out_operand, 32'h00000002);
    chk("R13 first carry", 32'(out_carry), 32'd0);
    in_shift_type = 2'd1; in_value = 32'h80000000; in_imm_amt = 5'd0; in_carry = 1'b0;
    #1;
    chk("R12 in_ready low while stalled", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R13 valid held", 32'(out_valid), 32'd1);
    chk("R13 operand held", out_operand, 32'h00000002);
    chk("R13 carry held", 32'(out_carry), 32'd0);
    out_ready = 1'b1;
    #1;
    chk("R12 in_ready follows out_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    chk("R13 waiting request operand", out_operand, 32'h00000000);
    chk("R3 waiting request carry", 32'(out_carry), 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R12 valid drops after drain", 32'(out_valid), 32'd0);

    report_and_end();
  end

endmodule